// File: doc/BRIEF.md
# Hashed Page Table Walker

This block finds the translation of one 4 KB page in a hashed page table that lives in memory. A request carries a 24-bit segment identifier, a 32-bit effective address and a flag that marks a store. The walker builds a compare tag and a hash from them. It then fetches table entries one at a time over a word-read port. It searches the eight entries of a primary group first. If none of them matches, it searches the eight entries of a secondary group. The secondary group is addressed with the complement of the hash.

When an entry matches, the walker reads its second word. If the referenced status bit is clear, or if a store finds the changed status bit clear, the walker sets that bit with a single-byte write. It then gives a one-cycle response with the hit flag, the entry's byte offset in the table, the entry's second word as it was read, the real address, and a flag saying whether the page must be treated as read-only for now. If all sixteen entries fail to match, it gives a miss response. The table base must be 64-byte aligned. The table-size mask selects the group address bits.

The controller is one state machine with these states:
- `ST_IDLE`: accepts a request.
- `ST_HDR_REQ` and `ST_HDR_WAIT`: issue the read of an entry's first word and wait for it.
- `ST_BODY_REQ` and `ST_BODY_WAIT`: do the same for the second word.
- `ST_MARK_REF` and `ST_MARK_CHG`: perform the byte writes.
- `ST_REPLY`: presents the result.

The transitions are:
- IDLE→HDR_REQ when a request is accepted.
- HDR_REQ→HDR_WAIT when the read is accepted.
- HDR_WAIT→BODY_REQ when the first word matches.
- HDR_WAIT→HDR_REQ to move to the next entry, or to the secondary group.
- HDR_WAIT→REPLY when the last secondary entry does not match.
- BODY_REQ→BODY_WAIT when the read is accepted.
- BODY_WAIT→MARK_REF, →MARK_CHG or →REPLY, depending on the status bits.
- MARK_REF→MARK_CHG or →REPLY.
- MARK_CHG→REPLY.
- REPLY→IDLE.

Top module: `hpt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1 and `rd_valid`, `wr_valid` and `rsp_valid` are 0.
- R2: The page index is `req_ea[27:12]`. The primary hash is `req_seg[18:0]` XOR the page index. A group offset is (hash << 6) AND `tbl_mask`. The first read address is `tbl_base` plus the primary group offset.
- R3: The first word of an entry is laid out as follows: bit 31 is valid, bits 30:7 are the segment identifier, bit 6 is the secondary flag, and bits 5:0 are compared with `req_ea[27:22]`. An entry matches only when it is valid, its flag equals the pass (0 for primary, 1 for secondary), and both tag fields are equal.
- R4: Entries are visited in order at group offset + 8·slot, for slots 0 to 7. The first word is read at offset +0. The second word, at +4, is read only after a matching first word. The search stops at the first match.
- R5: When no primary entry matches, the eight entries of the secondary group are searched. The secondary group offset is (complement of the 19-bit hash << 6) AND `tbl_mask`.
- R6: When none of the 16 entries matches, the walker responds with `rsp_hit`=0. On a miss, `rsp_offset`, `rsp_word1`, `rsp_raddr` and `rsp_no_write` are all 0.
- R7: On a hit, `rsp_offset` is the entry's byte offset from `tbl_base`. `rsp_word1` is the second word as it was read. `rsp_raddr` is `{word1[31:12], req_ea[11:0]}`.
- R8: When bit 8 (referenced) of the second word is clear, exactly one byte is written at entry offset +6. Its value is word1[15:8] with bit 0 set.
- R9: On a store whose word1 bit 7 (changed) is clear, one byte is written at entry offset +7. Its value is word1[7:0] with bit 7 set. This write comes after the referenced write when both are needed. No other byte writes happen.
- R10: `rsp_no_write` is 1 exactly on a hit by a non-store whose changed bit is clear.
- R11: `rd_valid` holds with a stable `rd_addr` until `rd_ready`, and `wr_valid` holds with a stable address and byte until `wr_ready`. Read data may return any number of cycles later, on `rd_resp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | 32 | Byte address of the table, 64-byte aligned |
| tbl_mask | input | 32 | Table-size mask applied to group offsets |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_seg | input | 24 | Segment identifier |
| req_ea | input | 32 | Effective address |
| req_store | input | 1 | Access is a store |
| rd_valid | output | 1 | Word read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 32 | Word read byte address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 32 | Read data |
| wr_valid | output | 1 | Byte write request |
| wr_ready | input | 1 | Byte write accepted |
| wr_addr | output | 32 | Byte write address |
| wr_byte | output | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_offset | output | 32 | Byte offset of the matching entry |
| rsp_word1 | output | 32 | Second word of the matching entry, as read |
| rsp_raddr | output | 32 | Real address |
| rsp_no_write | output | 1 | Page to be treated as not writable |

## Verification
The hardest case to reach from the ports is an entry that matches on every tag bit but is rejected anyway. This happens either because its secondary flag is wrong for the pass or because its valid bit is clear, and it has to sit ahead of the real entry in the scan. A random table almost never produces this. The bench therefore writes such decoys directly into its memory model, in front of planted entries in both primary and complement groups. Random read-acceptance, random read latency and random write acceptance then exercise the handshakes during these searches.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR_REQ,
        ST_HDR_WAIT,
        ST_BODY_REQ,
        ST_BODY_WAIT,
        ST_MARK_REF,
        ST_MARK_CHG,
        ST_REPLY
    } walk_state_e;

    localparam int unsigned GROUP_ENTRIES = 8;
    localparam int unsigned ENTRY_BYTES   = 8;
    localparam int unsigned WORD_BYTES    = 4;
    localparam int unsigned REF_BYTE_OFS  = 6;
    localparam int unsigned CHG_BYTE_OFS  = 7;
    localparam int unsigned REF_BIT       = 8;
    localparam int unsigned CHG_BIT       = 7;

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
    parameter int unsigned SEG_W     = 24,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PAGE_BITS = 12,
    parameter int unsigned PIDX_W    = 16,
    parameter int unsigned HASH_W    = 19,
    parameter int unsigned API_W     = 6,
    parameter int unsigned GRP_SHIFT = 6
) (
    input  logic [SEG_W-1:0]       seg,
    input  logic [ADDR_W-1:0]      ea,
    input  logic [ADDR_W-1:0]      mask,
    input  logic                   secondary,
    output logic [SEG_W+API_W:0]   tag,
    output logic [ADDR_W-1:0]      group_off
);
    localparam int unsigned TAG_W = SEG_W + API_W + 1;

    logic [PIDX_W-1:0] page_idx;
    logic [HASH_W-1:0] hash_pri;
    logic [HASH_W-1:0] hash_sel;

    always_comb begin
        page_idx  = ea[PAGE_BITS +: PIDX_W];
        hash_pri  = seg[HASH_W-1:0] ^ HASH_W'(page_idx);
        hash_sel  = secondary ? ~hash_pri : hash_pri;
        group_off = (ADDR_W'(hash_sel) << GRP_SHIFT) & mask;
        tag       = TAG_W'({seg, 1'b0, page_idx[PIDX_W-1 -: API_W]});
    end

endmodule

// File: rtl/hpt_entry_cmp.sv
module hpt_entry_cmp #(
    parameter int unsigned SEG_W  = 24,
    parameter int unsigned API_W  = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0]      hdr,
    input  logic [SEG_W+API_W:0]   tag,
    input  logic                   pass,
    output logic                   match
);
    localparam int unsigned FLAG_POS  = API_W;
    localparam int unsigned VALID_POS = DATA_W - 1;

    logic [SEG_W+API_W:0] hdr_tag;

    always_comb begin
        hdr_tag = {hdr[VALID_POS-1:FLAG_POS+1], 1'b0, hdr[API_W-1:0]};
        match   = hdr[VALID_POS] && (hdr[FLAG_POS] == pass) && (hdr_tag == tag);
    end

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int unsigned SEG_W  = 24,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [ADDR_W-1:0] tbl_mask,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [ADDR_W-1:0] req_ea,
    input  logic              req_store,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_resp_valid,
    input  logic [DATA_W-1:0] rd_resp_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_byte,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [ADDR_W-1:0] rsp_offset,
    output logic [DATA_W-1:0] rsp_word1,
    output logic [ADDR_W-1:0] rsp_raddr,
    output logic              rsp_no_write
);
    localparam int unsigned API_W     = 6;
    localparam int unsigned PAGE_BITS = 12;
    localparam int unsigned TAG_W     = SEG_W + API_W + 1;
    localparam int unsigned SLOT_W    = $clog2(GROUP_ENTRIES);
    localparam int unsigned ENT_SHIFT = $clog2(ENTRY_BYTES);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_ENTRIES - 1);

    walk_state_e state_q, state_d;

    logic [SEG_W-1:0]  seg_q;
    logic [ADDR_W-1:0] ea_q;
    logic              store_q;
    logic              pass_q;
    logic [SLOT_W-1:0] slot_q;
    logic              hit_q;
    logic [DATA_W-1:0] body_q;

    logic [TAG_W-1:0]  cmp_tag;
    logic [ADDR_W-1:0] group_off;
    logic [ADDR_W-1:0] entry_off;
    logic              hdr_match;
    logic              need_chg;

    hpt_hash #(
        .SEG_W     (SEG_W),
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS),
        .API_W     (API_W)
    ) u_hash (
        .seg       (seg_q),
        .ea        (ea_q),
        .mask      (tbl_mask),
        .secondary (pass_q),
        .tag       (cmp_tag),
        .group_off (group_off)
    );

    hpt_entry_cmp #(
        .SEG_W  (SEG_W),
        .API_W  (API_W),
        .DATA_W (DATA_W)
    ) u_cmp (
        .hdr   (rd_resp_data),
        .tag   (cmp_tag),
        .pass  (pass_q),
        .match (hdr_match)
    );

    assign entry_off = group_off + (ADDR_W'(slot_q) << ENT_SHIFT);
    assign need_chg  = store_q && !body_q[CHG_BIT];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_HDR_REQ;
            ST_HDR_REQ:   if (rd_ready) state_d = ST_HDR_WAIT;
            ST_HDR_WAIT: begin
                if (rd_resp_valid) begin
                    if (hdr_match)                       state_d = ST_BODY_REQ;
                    else if (pass_q && slot_q == LAST_SLOT) state_d = ST_REPLY;
                    else                                  state_d = ST_HDR_REQ;
                end
            end
            ST_BODY_REQ:  if (rd_ready) state_d = ST_BODY_WAIT;
            ST_BODY_WAIT: begin
                if (rd_resp_valid) begin
                    if (!rd_resp_data[REF_BIT])                  state_d = ST_MARK_REF;
                    else if (store_q && !rd_resp_data[CHG_BIT])  state_d = ST_MARK_CHG;
                    else                                         state_d = ST_REPLY;
                end
            end
            ST_MARK_REF:  if (wr_ready) state_d = need_chg ? ST_MARK_CHG : ST_REPLY;
            ST_MARK_CHG:  if (wr_ready) state_d = ST_REPLY;
            ST_REPLY:     state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q   <= '0;
            ea_q    <= '0;
            store_q <= 1'b0;
            pass_q  <= 1'b0;
            slot_q  <= '0;
            hit_q   <= 1'b0;
            body_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        seg_q   <= req_seg;
                        ea_q    <= req_ea;
                        store_q <= req_store;
                        pass_q  <= 1'b0;
                        slot_q  <= '0;
                        hit_q   <= 1'b0;
                        body_q  <= '0;
                    end
                end
                ST_HDR_WAIT: begin
                    if (rd_resp_valid && !hdr_match && !(pass_q && slot_q == LAST_SLOT)) begin
                        if (slot_q == LAST_SLOT) begin
                            slot_q <= '0;
                            pass_q <= 1'b1;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                ST_BODY_WAIT: begin
                    if (rd_resp_valid) begin
                        body_q <= rd_resp_data;
                        hit_q  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        rd_valid     = (state_q == ST_HDR_REQ) || (state_q == ST_BODY_REQ);
        rd_addr      = tbl_base + entry_off
                     + ((state_q == ST_BODY_REQ) ? ADDR_W'(WORD_BYTES) : '0);
        wr_valid     = (state_q == ST_MARK_REF) || (state_q == ST_MARK_CHG);
        wr_addr      = tbl_base + entry_off
                     + ((state_q == ST_MARK_CHG) ? ADDR_W'(CHG_BYTE_OFS) : ADDR_W'(REF_BYTE_OFS));
        wr_byte      = (state_q == ST_MARK_CHG) ? (body_q[7:0] | 8'h80)
                                                : (body_q[15:8] | 8'h01);
        rsp_valid    = (state_q == ST_REPLY);
        rsp_hit      = hit_q;
        rsp_offset   = hit_q ? entry_off : '0;
        rsp_word1    = hit_q ? body_q : '0;
        rsp_raddr    = hit_q ? {body_q[DATA_W-1:PAGE_BITS], ea_q[PAGE_BITS-1:0]} : '0;
        rsp_no_write = hit_q && !store_q && !body_q[CHG_BIT];
    end

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

    // R11
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_byte));

    // R11
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_valid));

    // R8
    ref_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_addr[2:0] == 3'd6 |-> wr_byte[0]);

    // R9
    chg_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_addr[2:0] == 3'd7 |-> wr_byte[7] && store_q);

    // R6
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit |-> rsp_offset == '0 && !rsp_no_write && rsp_raddr == '0);

    // R7
    reply_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);

endmodule

// File: tb/test_hpt_walker.sv
`timescale 1ns/1ps
module test_hpt_walker;

    localparam logic [31:0] BASE  = 32'h0002_0000;
    localparam logic [31:0] MASK  = 32'h0000_0FC0;
    localparam int          WORDS = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_seg = '0;
    logic [31:0] req_ea = '0;
    logic        req_store = 1'b0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [31:0] rd_addr;
    logic        rd_resp_valid = 1'b0;
    logic [31:0] rd_resp_data = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [31:0] wr_addr;
    logic [7:0]  wr_byte;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [31:0] rsp_offset;
    logic [31:0] rsp_word1;
    logic [31:0] rsp_raddr;
    logic        rsp_no_write;

    always #2.5 clk = ~clk;

    hpt_walker i_hpt_walker (
        .clk(clk), .rst_n(rst_n), .tbl_base(BASE), .tbl_mask(MASK),
        .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
        .req_ea(req_ea), .req_store(req_store),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_byte(wr_byte),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_offset(rsp_offset),
        .rsp_word1(rsp_word1), .rsp_raddr(rsp_raddr), .rsp_no_write(rsp_no_write)
    );

    logic [31:0] tbl [WORDS];
    int          vectors = 0;
    int          fails = 0;
    logic [31:0] rd_log [32];
    int          rd_n = 0;
    logic [31:0] wr_log_a [8];
    logic [7:0]  wr_log_b [8];
    int          wr_n = 0;
    int          hold_viol = 0;
    logic [31:0] exp_seq [32];
    int          e_nrd;
    logic        e_hit;
    logic [31:0] e_off;
    logic [31:0] e_w1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] grp(input logic [23:0] seg, input logic [31:0] ea, input bit sec);
        logic [18:0] h;
        h = seg[18:0] ^ {3'b000, ea[27:12]};
        if (sec) h = ~h;
        return ({13'd0, h} << 6) & MASK;
    endfunction

    function automatic logic [31:0] hdr_word(input logic [23:0] seg, input logic [31:0] ea, input bit sec, input bit vld);
        return {vld, seg, sec, ea[27:22]};
    endfunction

    task automatic put_entry(input logic [23:0] seg, input logic [31:0] ea, input bit sec,
                             input int slot, input logic [31:0] h0, input logic [31:0] w1);
        logic [31:0] o;
        o = grp(seg, ea, sec) + 32'(slot * 8);
        tbl[o >> 2] = h0;
        tbl[(o >> 2) + 1] = w1;
    endtask

    task automatic ref_walk(input logic [23:0] seg, input logic [31:0] ea);
        logic [31:0] o;
        logic [31:0] h0;
        e_hit = 1'b0; e_off = '0; e_w1 = '0; e_nrd = 0;
        for (int p = 0; p < 2 && !e_hit; p++) begin
            for (int s = 0; s < 8 && !e_hit; s++) begin
                o = grp(seg, ea, p[0]) + 32'(s * 8);
                exp_seq[e_nrd] = BASE + o; e_nrd++;
                h0 = tbl[o >> 2];
                if (h0[31] && h0[6] == p[0] && h0[30:7] == seg && h0[5:0] == ea[27:22]) begin
                    exp_seq[e_nrd] = BASE + o + 4; e_nrd++;
                    e_hit = 1'b1; e_off = o; e_w1 = tbl[(o >> 2) + 1];
                end
            end
        end
    endtask

    // memory model: random acceptance and latency
    initial begin
        bit          pend;
        int          lat;
        logic [31:0] idx;
        logic        prev_wait;
        logic [31:0] prev_addr;
        pend = 0; lat = 0; idx = 0; prev_wait = 0; prev_addr = 0;
        forever begin
            @(negedge clk);
            if (prev_wait && !(rd_valid && rd_addr == prev_addr)) hold_viol++;
            rd_resp_valid = 1'b0;
            if (pend) begin
                if (lat == 0) begin
                    rd_resp_valid = 1'b1;
                    rd_resp_data = tbl[idx];
                    pend = 0;
                end else lat--;
            end
            rd_ready = ($urandom_range(0, 3) != 0);
            prev_wait = rd_valid && !rd_ready;
            prev_addr = rd_addr;
            if (rd_valid && rd_ready) begin
                pend = 1;
                lat = $urandom_range(0, 3);
                idx = ((rd_addr - BASE) >> 2) & 32'(WORDS - 1);
                if (rd_n < 32) rd_log[rd_n] = rd_addr;
                rd_n++;
            end
            wr_ready = ($urandom_range(0, 2) != 0);
            if (wr_valid && wr_ready) begin
                logic [31:0] w;
                w = ((wr_addr - BASE) >> 2) & 32'(WORDS - 1);
                tbl[w][31 - 8 * wr_addr[1:0] -: 8] = wr_byte;
                if (wr_n < 8) begin
                    wr_log_a[wr_n] = wr_addr;
                    wr_log_b[wr_n] = wr_byte;
                end
                wr_n++;
            end
        end
    end

    task automatic run_walk(input logic [23:0] seg, input logic [31:0] ea, input bit st);
        logic [31:0] raddr_e;
        int          nw_e;
        int          guard;
        bit          seq_ok;
        logic [31:0] mem_w1;
        ref_walk(seg, ea);
        rd_n = 0; wr_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_seg = seg; req_ea = ea; req_store = st;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!rsp_valid && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        raddr_e = e_hit ? {e_w1[31:12], ea[11:0]} : 32'd0;
        chk(rsp_valid == 1'b1, "R6 response", {31'd0, rsp_valid}, 32'd1);
        chk(rsp_hit == e_hit, "R3 hit", {31'd0, rsp_hit}, {31'd0, e_hit});
        chk(rsp_offset == e_off, "R7 offset", rsp_offset, e_off);
        chk(rsp_word1 == e_w1, "R7 word1", rsp_word1, e_w1);
        chk(rsp_raddr == raddr_e, "R7 raddr", rsp_raddr, raddr_e);
        chk(rsp_no_write == (e_hit && !st && !e_w1[7]), "R10 no_write",
            {31'd0, rsp_no_write}, {31'd0, (e_hit && !st && !e_w1[7])});
        chk(rd_log[0] == exp_seq[0], "R2 first read", rd_log[0], exp_seq[0]);
        chk(rd_n == e_nrd, "R4 read count", 32'(rd_n), 32'(e_nrd));
        seq_ok = 1;
        for (int i = 0; i < e_nrd && i < rd_n; i++) if (rd_log[i] != exp_seq[i]) seq_ok = 0;
        chk(seq_ok, "R4 read order", 32'(rd_n), 32'(e_nrd));
        nw_e = 0;
        if (e_hit && !e_w1[8]) begin
            chk(wr_log_a[0] == BASE + e_off + 6 && wr_log_b[0] == (e_w1[15:8] | 8'h01),
                "R8 ref byte", {wr_log_a[0][23:0], wr_log_b[0]},
                {24'(BASE + e_off + 6), e_w1[15:8] | 8'h01});
            nw_e++;
        end
        if (e_hit && st && !e_w1[7]) begin
            chk(wr_log_a[nw_e] == BASE + e_off + 7 && wr_log_b[nw_e] == (e_w1[7:0] | 8'h80),
                "R9 chg byte", {wr_log_a[nw_e][23:0], wr_log_b[nw_e]},
                {24'(BASE + e_off + 7), e_w1[7:0] | 8'h80});
            nw_e++;
        end
        chk(wr_n == nw_e, "R9 write count", 32'(wr_n), 32'(nw_e));
        if (e_hit) begin
            mem_w1 = e_w1 | (32'(!e_w1[8]) << 8) | (32'(st && !e_w1[7]) << 7);
            chk(tbl[(e_off >> 2) + 1] == mem_w1, "R8 table word", tbl[(e_off >> 2) + 1], mem_w1);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [23:0] s;
        logic [31:0] a;
        void'($urandom(32'd20240917));
        for (int i = 0; i < WORDS; i++) tbl[i] = $urandom();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready", {31'd0, req_ready}, 32'd1);
        chk(!rd_valid && !wr_valid && !rsp_valid, "R1 idle outputs",
            {29'd0, rd_valid, wr_valid, rsp_valid}, 32'd0);

        // primary slot 0, load, both status bits clear
        s = 24'h12_3456; a = 32'h0ABC_D123;
        put_entry(s, a, 0, 0, hdr_word(s, a, 0, 1), {20'hABCDE, 3'b010, 1'b0, 1'b0, 7'h15});
        run_walk(s, a, 0);

        // primary slot 7, store, referenced set, changed clear
        s = 24'h00_0F0F; a = 32'h1234_5FFF;
        for (int k = 0; k < 7; k++) put_entry(s, a, 0, k, 32'h0, 32'h0);
        put_entry(s, a, 0, 7, hdr_word(s, a, 0, 1), {20'h00077, 3'b000, 1'b1, 1'b0, 7'h00});
        run_walk(s, a, 1);

        // store with both bits clear: two writes, R8 then R9 order
        s = 24'hFE_DCBA; a = 32'hF00D_B008;
        put_entry(s, a, 0, 1, hdr_word(s, a, 0, 1), {20'h55555, 3'b101, 1'b0, 1'b0, 7'h7F});
        put_entry(s, a, 0, 0, 32'h0, 32'h0);
        run_walk(s, a, 1);

        // R3 decoys: wrong flag and invalid entries ahead of the real one
        s = 24'h31_4159; a = 32'h2718_2818;
        for (int k = 0; k < 8; k++) put_entry(s, a, 0, k, 32'h0, 32'h0);
        put_entry(s, a, 0, 2, hdr_word(s, a, 1, 1), 32'hDEAD_0000);
        put_entry(s, a, 0, 3, hdr_word(s, a, 0, 0), 32'hBEEF_0000);
        put_entry(s, a, 0, 5, hdr_word(s, a, 0, 1), {20'h13579, 3'b000, 1'b1, 1'b1, 7'h01});
        run_walk(s, a, 1);
        chk(rsp_offset == grp(s, a, 0) + 40, "R3 decoys skipped", rsp_offset, grp(s, a, 0) + 40);

        // R5 secondary hit with a flag-0 decoy in the secondary group
        s = 24'h0A_0B0C; a = 32'h3344_5566;
        for (int k = 0; k < 8; k++) put_entry(s, a, 0, k, hdr_word(s, a, 1, 1), 32'h0);
        for (int k = 0; k < 8; k++) put_entry(s, a, 1, k, 32'h0, 32'h0);
        put_entry(s, a, 1, 1, hdr_word(s, a, 0, 1), 32'h0);
        put_entry(s, a, 1, 4, hdr_word(s, a, 1, 1), {20'hFEDCB, 3'b000, 1'b1, 1'b0, 7'h00});
        run_walk(s, a, 0);
        chk(rsp_offset == grp(s, a, 1) + 32, "R5 secondary group", rsp_offset, grp(s, a, 1) + 32);

        // R6 full miss
        s = 24'h77_7777; a = 32'h4444_0000;
        for (int k = 0; k < 8; k++) put_entry(s, a, 0, k, 32'h0, 32'h0);
        for (int k = 0; k < 8; k++) put_entry(s, a, 1, k, 32'h0, 32'h0);
        run_walk(s, a, 1);
        chk(!rsp_hit && rd_n == 16, "R6 miss after 16", 32'(rd_n), 32'd16);

        // both bits set, store: no writes, R10 flag low
        s = 24'h24_6802; a = 32'h5A5A_5A5A;
        put_entry(s, a, 0, 0, hdr_word(s, a, 0, 1), {20'h24680, 3'b000, 1'b1, 1'b1, 7'h00});
        run_walk(s, a, 1);

        // random mix
        for (int n = 0; n < 60; n++) begin
            s = 24'($urandom());
            a = $urandom();
            if ($urandom_range(0, 3) != 0)
                put_entry(s, a, $urandom_range(0, 1) == 1, $urandom_range(0, 7),
                          32'h0, 32'h0);
            if ($urandom_range(0, 4) != 0) begin
                bit sec;
                sec = ($urandom_range(0, 1) == 1);
                put_entry(s, a, sec, $urandom_range(0, 7), hdr_word(s, a, sec, 1), $urandom());
            end
            run_walk(s, a, $urandom_range(0, 1) == 1);
        end

        chk(hold_viol == 0, "R11 read hold", 32'(hold_viol), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule